// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Sequencer

This block reads one instruction of variable length from a memory addressed per character. A pulse on `start` with a starting address begins a scan. The block reads one character per cycle from left to right. The instruction ends when a character carrying a word mark appears after the operation code. That marked character opens the next instruction, so it is not taken into the current one. The characters that were taken are split into an operation code, a first address, a second address and a modifier character. The block also reports the true length and the address where the next instruction begins.

The memory port has one cycle of latency and never has more than one read in flight. The scan issues the next read in the same cycle in which the previous character comes back. Only the lengths 1, 2, 4, 5, 7 and 8 or more are accepted. A scan that ends at length 3 or 6, or that starts on a character without a word mark, raises an error pulse in place of the done pulse. Three configurable operation codes may end without a trailing word mark. One of them stops after four characters and the other two stop after seven.

Top module: `varlen_fetch_seq`

## Requirements
- R1: After reset, `busy`, `done`, `lenErr` and `memRe` are low and `nextPc` is zero.
- R2: A memory character is 8 bits: bit 7 is the word mark, bits 5:0 are the character code, and bit 6 is ignored. Reads go to consecutive addresses starting at `startAddr`, at most one per cycle. The data of a read is taken in the cycle after `memRe`.
- R3: After the operation code, the first character that carries a word mark ends the scan and is not part of the instruction. `nextPc` then equals that character's address.
- R4: The code of the first character becomes `opCode`. If the first character has no word mark, the scan ends at once with a `lenErr` pulse and no `done`.
- R5: `addrA` holds characters 2 to 4 and `addrB` holds characters 5 to 7. In each, the earliest character sits in bits 17:12 and the last in bits 5:0.
- R6: `modChar` equals the last character of a 2- or 5-character instruction, and character 8 of an instruction of 8 or more characters.
- R7: A scan of legal length ends with a one-cycle `done` pulse and no `lenErr`. A length of 3 or 6 gives a one-cycle `lenErr` pulse and no `done`.
- R8: Characters after the eighth do not change any field, but the scan goes on until a word mark. `instLen` gives the true length, held at 15 when the length is 15 or more.
- R9: If N characters are read, the end pulse appears N+1 cycles after the cycle in which `start` was taken. A 7-character instruction therefore reads 8 characters.
- R10: The branch code (default 0x32) ends the scan after its fourth character without reading a fifth. The two long codes (defaults 0x2C and 0x3C) end it after the seventh. In both cases `nextPc` is the start address plus the length. An earlier word mark still ends these scans first.
- R11: `start` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan (taken when idle) |
| startAddr | input | ADDR_W | Address of the operation code |
| memRe | output | 1 | Memory read request |
| memAddr | output | ADDR_W | Memory read address |
| memData | input | 8 | Character returned one cycle after the request |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Legal instruction fetched (one cycle) |
| lenErr | output | 1 | Illegal length or missing opcode mark (one cycle) |
| opCode | output | 6 | Operation code |
| addrA | output | 18 | First address, characters 2 to 4 |
| addrB | output | 18 | Second address, characters 5 to 7 |
| modChar | output | 6 | Modifier character |
| instLen | output | 4 | Instruction length, held at 15 |
| nextPc | output | ADDR_W | Start of the following instruction |

## Verification
Two end conditions can meet on one character. When a branch or long code has a word mark right at its fixed stop length, the mark test must win: the scan must stop before that character, one position earlier. The bench provokes a second overlap as well, where the length limit of a short-stop code meets the legality check at the same end cycle. The reference model walks memory on its own and predicts which condition ends the scan. It also predicts the exact read addresses, the end cycle and `nextPc`, and these are compared on every cycle.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int CODE_W      = 6;
  localparam int CHAR_W      = 8;
  localparam int MARK_BIT    = 7;
  localparam int FIELD_CHARS = 3;
  localparam int FIELD_W     = CODE_W * FIELD_CHARS;
  localparam int LEN_W       = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic             clearAll;
    logic             loadOp;
    logic             shiftA;
    logic             shiftB;
    logic             loadMod;
    logic             advance;
    logic             finish;
    logic             atMark;
    logic             noMark;
    logic [LEN_W-1:0] len;
  } fetchCtl_t;

  typedef enum logic {S_IDLE, S_SCAN} scanState_t;
endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             charMark,
  input  logic [LEN_W-1:0] shortLen,
  output logic             busy,
  output logic             memRe,
  output fetchCtl_t        ctl
);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;
  localparam logic [LEN_W-1:0] POS_A_LO = LEN_W'(2);
  localparam logic [LEN_W-1:0] POS_A_HI = LEN_W'(FIELD_CHARS + 1);
  localparam logic [LEN_W-1:0] POS_B_LO = LEN_W'(FIELD_CHARS + 2);
  localparam logic [LEN_W-1:0] POS_B_HI = LEN_W'(2 * FIELD_CHARS + 1);
  localparam logic [LEN_W-1:0] POS_MOD  = LEN_W'(2 * FIELD_CHARS + 2);
  localparam logic [LEN_W-1:0] ONE      = LEN_W'(1);

  scanState_t       state, nextState;
  logic [LEN_W-1:0] cnt, nextCnt, pos;

  // position of the character arriving now, held at the maximum
  assign pos  = (cnt == LEN_MAX) ? LEN_MAX : cnt + ONE;
  assign busy = (state == S_SCAN);

  always_comb begin
    ctl       = '0;
    memRe     = 1'b0;
    nextState = state;
    nextCnt   = cnt;
    case (state)
      S_IDLE: begin
        if (start) begin
          ctl.clearAll = 1'b1;
          memRe        = 1'b1;
          nextState    = S_SCAN;
          nextCnt      = '0;
        end
      end
      S_SCAN: begin
        if (cnt == '0) begin
          if (!charMark) begin
            ctl.finish = 1'b1;
            ctl.noMark = 1'b1;
            ctl.len    = ONE;
            nextState  = S_IDLE;
          end else begin
            ctl.loadOp  = 1'b1;
            ctl.advance = 1'b1;
            memRe       = 1'b1;
            nextCnt     = ONE;
          end
        end else if (charMark) begin
          ctl.finish = 1'b1;
          ctl.atMark = 1'b1;
          ctl.len    = cnt;
          nextState  = S_IDLE;
        end else begin
          ctl.advance = 1'b1;
          ctl.shiftA  = (pos >= POS_A_LO) && (pos <= POS_A_HI);
          ctl.shiftB  = (pos >= POS_B_LO) && (pos <= POS_B_HI);
          ctl.loadMod = (pos <= POS_MOD);
          nextCnt     = pos;
          if ((shortLen != '0) && (pos == shortLen)) begin
            ctl.finish = 1'b1;
            ctl.len    = pos;
            nextState  = S_IDLE;
          end else begin
            memRe = 1'b1;
          end
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
    end
  end
endmodule

// File: rtl/fetch_datapath.sv
module fetch_datapath
  import fetch_pkg::*;
#(
  parameter int                          ADDR_W    = 14,
  parameter logic [CODE_W-1:0]           BRANCH_OP = 6'h32,
  parameter int                          BR_LEN    = 4,
  parameter int                          N_LONG    = 2,
  parameter logic [N_LONG*CODE_W-1:0]    LONG_OPS  = {6'h3C, 6'h2C},
  parameter int                          LONG_LEN  = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  fetchCtl_t          ctl,
  input  logic [ADDR_W-1:0]  startAddr,
  input  logic [CHAR_W-1:0]  memData,
  output logic               charMark,
  output logic [LEN_W-1:0]   shortLen,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               done,
  output logic               lenErr,
  output logic [CODE_W-1:0]  opCode,
  output logic [FIELD_W-1:0] addrA,
  output logic [FIELD_W-1:0] addrB,
  output logic [CODE_W-1:0]  modChar,
  output logic [LEN_W-1:0]   instLen,
  output logic [ADDR_W-1:0]  nextPc
);
  localparam logic [LEN_W-1:0]  BR_LEN_C   = LEN_W'(BR_LEN);
  localparam logic [LEN_W-1:0]  LONG_LEN_C = LEN_W'(LONG_LEN);
  localparam logic [LEN_W-1:0]  BAD_LEN_A  = LEN_W'(3);
  localparam logic [LEN_W-1:0]  BAD_LEN_B  = LEN_W'(6);
  localparam logic [ADDR_W-1:0] STEP       = ADDR_W'(1);

  logic [ADDR_W-1:0] ptr;     // address of the character arriving now
  logic [CODE_W-1:0] charCode;
  logic [N_LONG-1:0] longHit;
  logic              badEnd;

  assign charMark = memData[MARK_BIT];
  assign charCode = memData[CODE_W-1:0];

  for (genvar i = 0; i < N_LONG; i++) begin : g_longMatch
    assign longHit[i] = (opCode == LONG_OPS[i*CODE_W +: CODE_W]);
  end

  assign shortLen = (opCode == BRANCH_OP) ? BR_LEN_C :
                    (|longHit)            ? LONG_LEN_C : '0;

  assign memAddr = ctl.clearAll ? startAddr : ptr + STEP;
  assign badEnd  = ctl.noMark || (ctl.len == BAD_LEN_A) || (ctl.len == BAD_LEN_B);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr     <= '0;
      opCode  <= '0;
      addrA   <= '0;
      addrB   <= '0;
      modChar <= '0;
      instLen <= '0;
      nextPc  <= '0;
      done    <= 1'b0;
      lenErr  <= 1'b0;
    end else begin
      done   <= ctl.finish && !badEnd;
      lenErr <= ctl.finish && badEnd;
      if (ctl.clearAll) begin
        ptr     <= startAddr;
        opCode  <= '0;
        addrA   <= '0;
        addrB   <= '0;
        modChar <= '0;
      end else begin
        if (ctl.advance) ptr <= ptr + STEP;
        if (ctl.loadOp)  opCode <= charCode;
        if (ctl.shiftA)  addrA <= {addrA[FIELD_W-CODE_W-1:0], charCode};
        if (ctl.shiftB)  addrB <= {addrB[FIELD_W-CODE_W-1:0], charCode};
        if (ctl.loadMod) modChar <= charCode;
      end
      if (ctl.finish) begin
        instLen <= ctl.len;
        nextPc  <= ctl.atMark ? ptr : ptr + STEP;
      end
    end
  end
endmodule

// File: rtl/varlen_fetch_seq.sv
module varlen_fetch_seq
  import fetch_pkg::*;
#(
  parameter int                         ADDR_W    = 14,
  parameter logic [CODE_W-1:0]          BRANCH_OP = 6'h32,
  parameter int                         BR_LEN    = 4,
  parameter int                         N_LONG    = 2,
  parameter logic [N_LONG*CODE_W-1:0]   LONG_OPS  = {6'h3C, 6'h2C},
  parameter int                         LONG_LEN  = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [ADDR_W-1:0]  startAddr,
  output logic               memRe,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic [7:0]         memData,
  output logic               busy,
  output logic               done,
  output logic               lenErr,
  output logic [5:0]         opCode,
  output logic [17:0]        addrA,
  output logic [17:0]        addrB,
  output logic [5:0]         modChar,
  output logic [3:0]         instLen,
  output logic [ADDR_W-1:0]  nextPc
);
  fetchCtl_t        ctl;
  logic             charMark;
  logic [LEN_W-1:0] shortLen;

  fetch_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .charMark (charMark),
    .shortLen (shortLen),
    .busy     (busy),
    .memRe    (memRe),
    .ctl      (ctl)
  );

  fetch_datapath #(
    .ADDR_W    (ADDR_W),
    .BRANCH_OP (BRANCH_OP),
    .BR_LEN    (BR_LEN),
    .N_LONG    (N_LONG),
    .LONG_OPS  (LONG_OPS),
    .LONG_LEN  (LONG_LEN)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .startAddr (startAddr),
    .memData   (memData),
    .charMark  (charMark),
    .shortLen  (shortLen),
    .memAddr   (memAddr),
    .done      (done),
    .lenErr    (lenErr),
    .opCode    (opCode),
    .addrA     (addrA),
    .addrB     (addrB),
    .modChar   (modChar),
    .instLen   (instLen),
    .nextPc    (nextPc)
  );
endmodule

// File: rtl/fetch_checker.sv
module fetch_checker #(
  parameter int          ADDR_W    = 14,
  parameter logic [5:0]  BRANCH_OP = 6'h32,
  parameter int          BR_LEN    = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              memRe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              busy,
  input logic              done,
  input logic              lenErr,
  input logic [5:0]        opCode,
  input logic [3:0]        instLen
);
  // R7: the two end pulses never coincide
  a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    !(done && lenErr));

  // R7: a done pulse never reports an illegal length
  a_r7_legal_len: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (instLen != 4'd3 && instLen != 4'd6 && instLen != 4'd0));

  // R2: back-to-back reads walk consecutive addresses
  a_r2_consecutive: assert property (@(posedge clk) disable iff (!rstN)
    (busy && memRe && $past(memRe)) |-> (memAddr == $past(memAddr) + ADDR_W'(1)));

  // R11: an idle read only comes from start
  a_r11_idle_read: assert property (@(posedge clk) disable iff (!rstN)
    (memRe && !busy) |-> start);

  // R9: the scan is over when a result is pulsed
  a_r9_end_idle: assert property (@(posedge clk) disable iff (!rstN)
    (done || lenErr) |-> !busy);

  // R7: each pulse lasts a single cycle
  a_r7_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (done || lenErr) |=> !(done || lenErr));

  // R10: the branch code never exceeds its stop length
  a_r10_branch_len: assert property (@(posedge clk) disable iff (!rstN)
    (done && opCode == BRANCH_OP) |-> (instLen <= 4'(BR_LEN)));
endmodule

bind varlen_fetch_seq fetch_checker #(
  .ADDR_W    (ADDR_W),
  .BRANCH_OP (BRANCH_OP),
  .BR_LEN    (BR_LEN)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .memRe   (memRe),
  .memAddr (memAddr),
  .busy    (busy),
  .done    (done),
  .lenErr  (lenErr),
  .opCode  (opCode),
  .instLen (instLen)
);

// File: tb/sim_varlen_fetch_seq.sv
module sim_varlen_fetch_seq;
  localparam int ADDR_W = 14;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic              memRe;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0]        memData;
  logic              busy, done, lenErr;
  logic [5:0]        opCode, modChar;
  logic [17:0]       addrA, addrB;
  logic [3:0]        instLen;
  logic [ADDR_W-1:0] nextPc;

  logic [7:0] mem [256];
  logic [7:0] memQ = '0;
  int nChk = 0;
  int nFail = 0;

  always #10 clk = ~clk;  // 50 MHz

  varlen_fetch_seq u0 (.*);

  always_ff @(posedge clk) if (memRe) memQ <= mem[memAddr[7:0]];
  assign memData = memQ;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // write an instruction: op with mark, n-1 plain chars, then mark or blank
  task automatic place(int base, int n, logic [5:0] op, bit blankTail);
    mem[base] = {1'b1, op[1], op};
    for (int i = 1; i < n; i++) begin
      logic [5:0] code = 6'(base + 5 * i + 3);
      mem[(base + i) & 255] = {1'b0, code[1], code};
    end
    mem[(base + n) & 255]     = blankTail ? 8'h00 : 8'h81;
    mem[(base + n + 1) & 255] = 8'h81;
  endtask

  function automatic int stopFor(logic [5:0] op);
    if (op == 6'h32) return 4;
    if (op == 6'h2C || op == 6'h3C) return 7;
    return 0;
  endfunction

  task automatic runCase(string tag, int base, int holdCycles);
    int reads[$];
    logic [5:0]  eOp = '0, eMod = '0;
    logic [17:0] eA = '0, eB = '0;
    int eLen = 0, eNext = 0, nRead = 0, cyc = 0, sl;
    bit eErr = 0;
    logic [7:0] c;
    // reference walk over memory
    c = mem[base & 255]; reads.push_back(base); nRead = 1;
    if (!c[7]) begin
      eErr = 1; eLen = 1; eNext = base + 1;
    end else begin
      eOp = c[5:0]; sl = stopFor(eOp);
      for (int p = 2; p < 64; p++) begin
        c = mem[(base + p - 1) & 255]; reads.push_back(base + p - 1); nRead++;
        if (c[7]) begin eLen = p - 1; eNext = base + p - 1; break; end
        if (p <= 4) eA = 18'((eA << 6) | c[5:0]);
        else if (p <= 7) eB = 18'((eB << 6) | c[5:0]);
        if (p <= 8) eMod = c[5:0];
        if (sl != 0 && p == sl) begin eLen = p; eNext = base + p; break; end
      end
      eErr = (eLen == 3 || eLen == 6);
    end
    // drive start and follow cycle by cycle
    startAddr = ADDR_W'(base);
    start = 1'b1;
    #1;
    if (memRe) chk("R2", {tag, " read addr"}, 32'(memAddr), 32'(reads.pop_front()));
    else chk("R2", {tag, " first read"}, 0, 1);
    while (1) begin
      @(negedge clk); cyc++;
      if (cyc > holdCycles) start = 1'b0;
      #1;
      if (done || lenErr || cyc > 60) break;
      if (memRe) begin
        if (reads.size() == 0) chk("R2", {tag, " extra read"}, 32'(memAddr), 0);
        else if (memAddr !== ADDR_W'(reads[0])) begin
          chk("R11", {tag, " read addr"}, 32'(memAddr), 32'(reads[0]));
          void'(reads.pop_front());
        end else void'(reads.pop_front());
      end
    end
    chk("R9", {tag, " end cycle"}, 32'(cyc), 32'(nRead + 1));
    chk("R2", {tag, " reads left"}, 32'(reads.size()), 0);
    chk("R7", {tag, " done"}, 32'(done), 32'(!eErr));
    chk("R7", {tag, " lenErr"}, 32'(lenErr), 32'(eErr));
    chk("R3", {tag, " nextPc"}, 32'(nextPc), 32'(eNext));
    chk("R8", {tag, " instLen"}, 32'(instLen), 32'(eLen > 15 ? 15 : eLen));
    if (!eErr) begin
      chk("R4", {tag, " opCode"}, 32'(opCode), 32'(eOp));
      chk("R5", {tag, " addrA"}, 32'(addrA), 32'(eA));
      chk("R5", {tag, " addrB"}, 32'(addrB), 32'(eB));
      if (eLen == 2 || eLen == 5 || eLen >= 8)
        chk("R6", {tag, " modChar"}, 32'(modChar), 32'(eMod));
    end
    @(negedge clk); #1;
    chk("R7", {tag, " pulse width"}, 32'(done | lenErr), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "done", 32'(done), 0);
    chk("R1", "lenErr", 32'(lenErr), 0);
    chk("R1", "memRe", 32'(memRe), 0);
    chk("R1", "nextPc", 32'(nextPc), 0);
    @(negedge clk);

    place(10, 1, 6'h11, 0);   runCase("R7 len1", 10, 1);
    place(20, 2, 6'h12, 0);   runCase("R6 len2", 20, 1);
    place(30, 4, 6'h13, 0);   runCase("R5 len4", 30, 1);
    place(40, 5, 6'h14, 0);   runCase("R11 len5 held start", 40, 4);
    place(50, 7, 6'h15, 0);   runCase("R9 len7", 50, 1);
    place(60, 8, 6'h16, 0);   runCase("R6 len8", 60, 1);
    place(70, 3, 6'h17, 0);   runCase("R7 len3", 70, 1);
    place(80, 6, 6'h18, 0);   runCase("R7 len6", 80, 1);
    place(90, 11, 6'h19, 0);  runCase("R8 len11", 90, 1);
    place(110, 4, 6'h32, 1);  runCase("R10 branch stop", 110, 1);
    place(120, 2, 6'h32, 0);  runCase("R10 branch early mark", 120, 1);
    place(130, 7, 6'h2C, 1);  runCase("R10 long A stop", 130, 1);
    place(140, 7, 6'h3C, 1);  runCase("R10 long B stop", 140, 1);
    place(150, 3, 6'h32, 0);  runCase("R10 branch len3", 150, 1);
    place(160, 4, 6'h2C, 0);  runCase("R10 long mark at4", 160, 1);
    place(170, 3, 6'h1A, 0);  mem[170] = 8'h1A;
    runCase("R4 missing mark", 170, 1);
    place(180, 17, 6'h1B, 0); runCase("R8 len17", 180, 1);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL R9 watchdog expired: actual running expected finished");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule